// File: doc/BRIEF.md
# UART Automatic Hardware Handshake

This block is the handshake engine that sits between a UART's FIFOs and its modem pins. On the receive side it watches the receive FIFO fill level. It pulls the RTS pin inactive (high) when the level reaches a programmable trigger. It lets RTS go active (low) again only after the level has fallen two entries below that trigger. The gap between the two thresholds keeps the pin from chattering while software or DMA drains the FIFO one entry at a time.

On the transmit side it synchronizes the CTS pin and produces a transmit-allowed flag. The serializer consults that flag only when it is about to start a new character, so a stall always lands on a character boundary. The transmitter raises a late-stop indication from the middle of the last stop bit until the character ends. While that indication is high the allow decision is frozen, so a CTS deassertion that arrives in that window lets exactly one more character out.

A falling edge on the synchronized CTS line, with automatic flow enabled, latches a modem interrupt. The interrupt holds until software pulses the clear input.

Top module: `uart_flow_ctl`

## Requirements
- R1: Automatic RTS is in force only when `afc_en`, `rts_sw` and `fifo_en` are all 1; with any of them 0, the fill level has no effect on `rts_n`.
- R2: Automatic CTS additionally requires `irda_en` = 0; with `irda_en` = 1, `tx_allow` is 1 at the first clock edge at which `tx_late_stop` is 0.
- R3: With automatic RTS in force, `rts_n` is 1 from the clock edge after `rx_level` reaches or exceeds the trigger.
- R4: After blocking, `rts_n` stays 1 while `rx_level` is at or above trigger minus 2, and returns to 0 one edge after `rx_level` drops below trigger minus 2.
- R5: `trig_sel` encodes the trigger as 0 = 1 entry, 1 = DEPTH/4, 2 = DEPTH/2, 3 = DEPTH-2 (with DEPTH = 16: 1, 4, 8, 14).
- R6: With the 1-entry trigger, RTS is released only when `rx_level` is 0.
- R7: With automatic RTS not in force, `rts_n` is the inverse of `rts_sw` in the same cycle.
- R8: `cts_n` passes through two flops. With automatic CTS in force and `tx_late_stop` = 0, `tx_allow` follows `!cts_n` three clock edges after the pin changes.
- R9: While `tx_late_stop` is 1, `tx_allow` holds its value whatever `cts_n` does, so at most one further character starts after a late CTS deassertion.
- R10: A synchronized high-to-low CTS transition with `afc_en` = 1 sets `modem_irq` one edge after that transition shows at the second sync flop. `modem_irq` stays 1 until `irq_clr` is 1 at an edge. No transition sets it while `afc_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| afc_en | input | 1 | Automatic flow control enable |
| rts_sw | input | 1 | Software RTS request (1 = assert) |
| fifo_en | input | 1 | FIFOs enabled |
| irda_en | input | 1 | Infrared mode active |
| rx_level | input | LW | Receive FIFO fill level |
| trig_sel | input | 2 | Trigger select (see R5) |
| cts_n | input | 1 | CTS pin, active low, asynchronous |
| tx_late_stop | input | 1 | Transmitter is past the middle of its last stop bit |
| irq_clr | input | 1 | Modem interrupt clear pulse |
| rts_n | output | 1 | RTS pin, active low |
| tx_allow | output | 1 | Next character may start |
| modem_irq | output | 1 | Latched CTS-fall interrupt |

## Verification
The bench walks each trigger setting through the exact level at the trigger, one below it, and the two levels on each side of the release point. A design whose hysteresis is off by one would release at trigger minus 2 or keep RTS blocked one entry too long. The one-entry trigger is checked separately: a naive subtraction would wrap and never release, or would release at level 1. CTS is toggled inside the late-stop window to catch a design that stalls mid-window, which would lose the extra character. CTS falls are also driven with flow control off, to catch an interrupt that ignores its enable. Latencies are sampled on exact edges, so a missing or extra synchronizer flop shows as a miss.

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          afc_en,
  input  logic          rts_sw,
  input  logic          fifo_en,
  input  logic          irda_en,
  input  logic [LW-1:0] rx_level,
  input  logic [1:0]    trig_sel,
  input  logic          cts_n,
  input  logic          tx_late_stop,
  input  logic          irq_clr,
  output logic          rts_n,
  output logic          tx_allow,
  output logic          modem_irq
);

  logic          auto_rts, auto_cts;
  logic [LW-1:0] trig, rel;
  logic          blocked_q;
  logic          cts_m, cts_s, cts_d;
  logic          allow_q;

  assign auto_rts = afc_en & rts_sw & fifo_en;
  assign auto_cts = auto_rts & ~irda_en;

  always_comb begin
    case (trig_sel)
      2'd0:    trig = LW'(1);
      2'd1:    trig = LW'(DEPTH / 4);
      2'd2:    trig = LW'(DEPTH / 2);
      default: trig = LW'(DEPTH - 2);
    endcase
    rel = (trig > LW'(2)) ? trig - LW'(2) : LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                blocked_q <= 1'b0;
    else if (!auto_rts)        blocked_q <= 1'b0;
    else if (rx_level >= trig) blocked_q <= 1'b1;
    else if (rx_level < rel)   blocked_q <= 1'b0;

  assign rts_n = auto_rts ? blocked_q : ~rts_sw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {cts_m, cts_s, cts_d} <= 3'b111;
    else        {cts_m, cts_s, cts_d} <= {cts_n, cts_m, cts_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             allow_q <= 1'b1;
    else if (!tx_late_stop) allow_q <= ~auto_cts | ~cts_s;

  assign tx_allow = allow_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        modem_irq <= 1'b0;
    else if (cts_d & ~cts_s & afc_en)  modem_irq <= 1'b1;
    else if (irq_clr)                  modem_irq <= 1'b0;

  a_r3_block_at_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts && rx_level >= trig) |=> (rts_n || !auto_rts));

  a_r4_release_below: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts && rx_level < rel) |=> (!rts_n || !auto_rts));

  a_r9_frozen_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_late_stop && $past(tx_late_stop)) |-> $stable(tx_allow));

  a_r2_irda_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (irda_en && !tx_late_stop) |=> tx_allow);

  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (modem_irq && !irq_clr) |=> modem_irq);

endmodule

// File: tb/sim_uart_flow_ctl.sv
module sim_uart_flow_ctl;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic afc_en = 0, rts_sw = 0, fifo_en = 0, irda_en = 0;
  logic [LW-1:0] rx_level = '0;
  logic [1:0] trig_sel = 2'd0;
  logic cts_n = 1, tx_late_stop = 0, irq_clr = 0;
  logic rts_n, tx_allow, modem_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_flow_ctl #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .afc_en(afc_en), .rts_sw(rts_sw),
    .fifo_en(fifo_en), .irda_en(irda_en), .rx_level(rx_level),
    .trig_sel(trig_sel), .cts_n(cts_n), .tx_late_stop(tx_late_stop),
    .irq_clr(irq_clr), .rts_n(rts_n), .tx_allow(tx_allow),
    .modem_irq(modem_irq));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk(rts_n, 1'b1, "R7 reset rts_n");
    chk(tx_allow, 1'b1, "R8 reset tx_allow");
    chk(modem_irq, 1'b0, "R10 reset modem_irq");
  endtask

  task automatic t_manual;
    rts_sw = 1; rx_level = LW'(16); step(1);
    chk(rts_n, 1'b0, "R7 sw assert");
    rts_sw = 0; #1;
    chk(rts_n, 1'b1, "R7 sw deassert");
    rts_sw = 1; afc_en = 1; step(2);
    chk(rts_n, 1'b0, "R1 fifo off ignores level");
    fifo_en = 1; step(1);
    chk(rts_n, 1'b1, "R1 all enables block");
    rx_level = '0; step(1);
  endtask

  task automatic t_trig(input logic [1:0] sel, input int t);
    trig_sel = sel;
    rx_level = LW'(t - 1); step(1);
    chk(rts_n, 1'b0, "R5 below trigger");
    rx_level = LW'(t); step(1);
    chk(rts_n, 1'b1, "R3 at trigger");
    rx_level = LW'(t - 2); step(1);
    chk(rts_n, 1'b1, "R4 hold at trig-2");
    rx_level = LW'(t - 3); step(1);
    chk(rts_n, 1'b0, "R4 release below trig-2");
  endtask

  task automatic t_trig1;
    trig_sel = 2'd0;
    rx_level = LW'(1); step(1);
    chk(rts_n, 1'b1, "R6 trigger 1 blocks");
    step(2);
    chk(rts_n, 1'b1, "R6 held at level 1");
    rx_level = '0; step(1);
    chk(rts_n, 1'b0, "R6 release at empty");
  endtask

  task automatic t_cts;
    cts_n = 1; step(2);
    chk(tx_allow, 1'b1, "R8 not yet through sync");
    step(1);
    chk(tx_allow, 1'b0, "R8 stalled after 3 edges");
    irda_en = 1; step(1);
    chk(tx_allow, 1'b1, "R2 irda disables stall");
    irda_en = 0; step(1);
    chk(tx_allow, 1'b0, "R2 stall returns");
    cts_n = 0; step(3);
    chk(tx_allow, 1'b1, "R8 resume");
  endtask

  task automatic t_late;
    tx_late_stop = 1; cts_n = 1; step(5);
    chk(tx_allow, 1'b1, "R9 extra char allowed");
    tx_late_stop = 0; step(1);
    chk(tx_allow, 1'b0, "R9 stall at boundary");
    tx_late_stop = 1; cts_n = 0; step(5);
    chk(tx_allow, 1'b0, "R9 frozen low");
    tx_late_stop = 0; step(1);
    chk(tx_allow, 1'b1, "R9 resume after window");
  endtask

  task automatic t_irq;
    cts_n = 1; irq_clr = 1; step(4);
    irq_clr = 0; step(1);
    chk(modem_irq, 1'b0, "R10 cleared");
    cts_n = 0; step(2);
    chk(modem_irq, 1'b0, "R10 not yet set");
    step(1);
    chk(modem_irq, 1'b1, "R10 set on fall");
    step(5);
    chk(modem_irq, 1'b1, "R10 holds");
    irq_clr = 1; step(1);
    irq_clr = 0;
    chk(modem_irq, 1'b0, "R10 clear pulse");
    afc_en = 0; cts_n = 1; step(4);
    cts_n = 0; step(4);
    chk(modem_irq, 1'b0, "R10 no set with afc off");
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_n = 1; step(1);
    t_reset;
    t_manual;
    t_trig(2'd1, 4);
    t_trig(2'd2, 8);
    t_trig(2'd3, 14);
    t_trig1;
    cts_n = 0; step(4);
    t_cts;
    t_late;
    t_irq;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule